// File: doc/BRIEF.md
# Predicated-Block Status Word Register

This block holds a 32-bit processor status word. Inside that word sits an 8-bit conditional-execution state, which tracks a run of up to four predicated instructions. The state is not stored in one place in the word. Its two low bits sit at word bits 26:25, and its six upper bits sit at word bits 15:10. The other fields are the flags N, Z, C, V and Q at bits 31..27, J at 24, reserved bits 23:20, the four GE flags at 19:16, E/A/I/F/T at 9..5, and the mode at 4:0. Every bit outside the conditional state is kept exactly as written.

Software or a pipeline loads the whole word with a write strobe and reads it back packed. The retire stage pulses an advance strobe once per retired instruction, and each pulse steps the conditional state by one. The block also drives two outputs:
- the current condition, which is state bits 7:4 (word bits 15:12);
- an in-block flag.

Internally the state is classified into five phases from state bits 3:0:
- IDLE (0000);
- LAST (1000);
- TWO (x100);
- THREE (xx10);
- FOUR (xxx1).

An advance moves FOUR to THREE, THREE to TWO, TWO to LAST, and LAST to IDLE. From IDLE an advance stays in IDLE.

Top module: `cond_status_reg`

## Requirements
- R1: A synchronous reset clears the whole status word to zero, so the condition output and the in-block flag read 0.
- R2: A write loads all 32 bits, reserved bits 23:20 included, and the next cycle reads back exactly the written word.
- R3: The state is packed with state[1:0] at word bits 26:25 and state[7:2] at word bits 15:10. The condition output equals state[7:4], which is word bits 15:12.
- R4: An advance when state[2:0] is 000 clears all eight state bits to zero.
- R5: An advance when state[2:0] is nonzero keeps state[7:5], shifts state[4:0] left by one with a zero fill, and drops the old state[4].
- R6: An advance leaves every word bit outside the two state fields unchanged.
- R7: When a write and an advance occur in the same cycle, the written word is loaded unchanged.
- R8: The in-block flag is 1 exactly when state[3:0] is nonzero, whatever the condition bits hold.
- R9: With neither strobe asserted, the word holds its value.
- R10: A block loaded with state[3:0] = 0001 keeps the in-block flag high for exactly four advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Load the whole status word |
| wr_word | input | 32 | Word to load |
| adv_en | input | 1 | Step the conditional state for one retired instruction |
| status_word | output | 32 | Packed status word |
| cond_code | output | 4 | Current condition, state[7:4] |
| in_block | output | 1 | A predicated block is in progress |

## Verification
Two situations cannot be reached by advancing alone; only a direct write can set them up. The first is a state whose condition bits are nonzero while its mask bits are empty. The second is a state in which old bit 4 is set and must be dropped by the shift. The stimulus therefore loads such states with writes, then advances them.

A write and an advance in the same cycle must still load the written word untouched. The table drives that case directly, using an all-ones word so that every reserved bit is visible.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int WORD_W  = 32;
    localparam int STATE_W = 8;
    // split placement of the conditional state inside the word
    localparam int LO_POS  = 25;   // state[1:0]
    localparam int HI_POS  = 10;   // state[7:2]
    localparam int LO_W    = 2;
    localparam int HI_W    = STATE_W - LO_W;
    localparam int COND_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LAST,
        PH_TWO,
        PH_THREE,
        PH_FOUR
    } cst_phase_e;

    function automatic logic [WORD_W-1:0] state_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[LO_POS +: LO_W] = '1;
        m[HI_POS +: HI_W] = '1;
        return m;
    endfunction
endpackage

// File: rtl/cst_field_split.sv
module cst_field_split
    import cst_pkg::*;
(
    input  logic [WORD_W-1:0]  word_in,
    output logic [STATE_W-1:0] state_out,
    output logic [WORD_W-1:0]  other_out
);
    always_comb begin
        state_out = {word_in[HI_POS +: HI_W], word_in[LO_POS +: LO_W]};
        other_out = word_in & ~state_mask();
    end
endmodule

// File: rtl/cst_phase_decode.sv
module cst_phase_decode
    import cst_pkg::*;
(
    input  logic [STATE_W-1:0] state_in,
    output cst_phase_e         phase
);
    always_comb begin
        unique casez (state_in[3:0])
            4'b0000: phase = PH_IDLE;
            4'b1000: phase = PH_LAST;
            4'b?100: phase = PH_TWO;
            4'b??10: phase = PH_THREE;
            4'b???1: phase = PH_FOUR;
            default: phase = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/cst_advance.sv
module cst_advance
    import cst_pkg::*;
(
    input  logic [STATE_W-1:0] state_in,
    input  cst_phase_e         phase,
    output logic [STATE_W-1:0] state_next
);
    always_comb begin
        unique case (phase)
            PH_IDLE, PH_LAST:
                state_next = '0;
            PH_TWO, PH_THREE, PH_FOUR:
                state_next = {state_in[STATE_W-1:5], state_in[3:0], 1'b0};
            default:
                state_next = '0;
        endcase
    end
endmodule

// File: rtl/cond_status_reg.sv
module cond_status_reg
    import cst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    input  logic        adv_en,
    output logic [31:0] status_word,
    output logic [3:0]  cond_code,
    output logic        in_block
);
    localparam logic [WORD_W-1:0] OTHER_MASK = ~state_mask();

    logic [STATE_W-1:0] state_q;
    logic [WORD_W-1:0]  other_q;
    logic [STATE_W-1:0] wr_state;
    logic [WORD_W-1:0]  wr_other;
    logic [STATE_W-1:0] adv_state;
    cst_phase_e         phase;

    cst_field_split u_split (
        .word_in   (wr_word),
        .state_out (wr_state),
        .other_out (wr_other)
    );

    cst_phase_decode u_decode (
        .state_in (state_q),
        .phase    (phase)
    );

    cst_advance u_adv (
        .state_in   (state_q),
        .phase      (phase),
        .state_next (adv_state)
    );

    // state register: write wins over advance
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            other_q <= '0;
        end else if (wr_en) begin
            state_q <= wr_state;
            other_q <= wr_other;
        end else if (adv_en) begin
            state_q <= adv_state;
        end
    end

    // outputs
    always_comb begin
        status_word = other_q;
        status_word[LO_POS +: LO_W] = state_q[LO_W-1:0];
        status_word[HI_POS +: HI_W] = state_q[STATE_W-1:LO_W];
        cond_code = state_q[STATE_W-1 -: COND_W];
        in_block  = (phase != PH_IDLE);
    end

    assert_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> status_word == $past(wr_word));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && adv_en && state_q[2:0] == 3'b000) |=> state_q == '0);

    assert_shift_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && adv_en && state_q[2:0] != 3'b000) |=>
        (state_q[7:5] == $past(state_q[7:5]) && state_q[4:1] == $past(state_q[3:0]) && !state_q[0]));

    assert_outside_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && adv_en) |=> (status_word & OTHER_MASK) == $past(status_word & OTHER_MASK));

    assert_inblock_R8: assert property (@(posedge clk) disable iff (rst)
        in_block == (status_word[11:10] != 2'b00 || status_word[26:25] != 2'b00));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !adv_en) |=> $stable(status_word));
endmodule

// File: tb/cond_status_reg_bench.sv
module cond_status_reg_bench;
    localparam logic [31:0] OUT_MASK = 32'hF9FF_03FF;

    function automatic logic [31:0] mk(input logic [7:0] st, input logic [31:0] o);
        logic [31:0] w;
        w = o & OUT_MASK;
        w[26:25] = st[1:0];
        w[15:10] = st[7:2];
        return w;
    endfunction

    typedef struct packed {
        logic        wr;
        logic        adv;
        logic [31:0] din;
        logic [31:0] exp_word;
        logic [3:0]  exp_cond;
        logic        exp_inb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, mk(8'h00, 32'hA5A5_A5A5), mk(8'h00, 32'hA5A5_A5A5), 4'h0, 1'b0, 4'd2}, // R2
        '{1'b1, 1'b0, mk(8'hA1, 32'h1234_5678), mk(8'hA1, 32'h1234_5678), 4'hA, 1'b1, 4'd3}, // R3
        '{1'b0, 1'b1, 32'h0, mk(8'hA2, 32'h1234_5678), 4'hA, 1'b1, 4'd5},                   // R5
        '{1'b0, 1'b1, 32'h0, mk(8'hA4, 32'h1234_5678), 4'hA, 1'b1, 4'd5},                   // R5
        '{1'b0, 1'b1, 32'h0, mk(8'hA8, 32'h1234_5678), 4'hA, 1'b1, 4'd6},                   // R6
        '{1'b0, 1'b1, 32'h0, mk(8'h00, 32'h1234_5678), 4'h0, 1'b0, 4'd4},                   // R4
        '{1'b0, 1'b1, 32'h0, mk(8'h00, 32'h1234_5678), 4'h0, 1'b0, 4'd4},                   // R4
        '{1'b0, 1'b0, 32'hFFFF_FFFF, mk(8'h00, 32'h1234_5678), 4'h0, 1'b0, 4'd9},           // R9
        '{1'b1, 1'b1, mk(8'h5C, 32'hFFFF_FFFF), mk(8'h5C, 32'hFFFF_FFFF), 4'h5, 1'b1, 4'd7}, // R7
        '{1'b0, 1'b1, 32'h0, mk(8'h58, 32'hFFFF_FFFF), 4'h5, 1'b1, 4'd5},                   // R5
        '{1'b0, 1'b1, 32'h0, mk(8'h00, 32'hFFFF_FFFF), 4'h0, 1'b0, 4'd4},                   // R4
        '{1'b1, 1'b0, mk(8'hF0, 32'h0), mk(8'hF0, 32'h0), 4'hF, 1'b0, 4'd8},                // R8
        '{1'b0, 1'b1, 32'h0, 32'h0, 4'h0, 1'b0, 4'd4},                                      // R4
        '{1'b1, 1'b0, mk(8'h37, 32'h0), mk(8'h37, 32'h0), 4'h3, 1'b1, 4'd3},                // R3
        '{1'b0, 1'b1, 32'h0, mk(8'h2E, 32'h0), 4'h2, 1'b1, 4'd5}                            // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        adv_en = 1'b0;
    logic [31:0] status_word;
    logic [3:0]  cond_code;
    logic        in_block;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cond_status_reg u_cond_status_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .adv_en(adv_en), .status_word(status_word),
        .cond_code(cond_code), .in_block(in_block)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 word", status_word, 32'h0);
        chk("R1 cond", {28'h0, cond_code}, 32'h0);
        chk("R1 inblk", {31'h0, in_block}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr_en = VECS[i].wr;
            adv_en = VECS[i].adv;
            wr_word = VECS[i].din;
            @(negedge clk);
            chk($sformatf("R%0d vec%0d word", VECS[i].req, i), status_word, VECS[i].exp_word);
            chk($sformatf("R%0d vec%0d cond", VECS[i].req, i), {28'h0, cond_code}, {28'h0, VECS[i].exp_cond});
            chk($sformatf("R%0d vec%0d inblk", VECS[i].req, i), {31'h0, in_block}, {31'h0, VECS[i].exp_inb});
        end

        // R10: a four-instruction block lasts four advances
        wr_en = 1'b1; adv_en = 1'b0; wr_word = mk(8'h61, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        n = 0;
        while (in_block && n < 10) begin
            adv_en = 1'b1;
            @(negedge clk);
            n++;
        end
        adv_en = 1'b0;
        chk("R10 advances", n, 4);
        chk("R10 word", status_word, 32'h0);

        // R1 reset mid-run, with a write pending in the same cycle
        wr_en = 1'b1; wr_word = 32'hFFFF_FFFF;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        chk("R1 midrun word", status_word, 32'h0);
        chk("R1 midrun inblk", {31'h0, in_block}, 32'h0);
        finish_run();
    end
endmodule